// File: doc/BRIEF.md
# Cache Mode Control Register File

This block is the register file that a processor core uses to set and read the operating mode of its instruction and data caches. It holds one writable control word and answers two fixed configuration words. Software reaches all three through a 32-bit register port: an address, a write enable, an access size, write data and combinational read data. No cache arrays, flush engines or snoop logic exist behind it. The mode fields only record what software asked for.

The control word holds a 2-bit mode for each cache, a freeze-on-interrupt enable for each cache, and a data snoop enable. Several command and pending positions are never stored. A write always clears them, so they always read as zero. When the core takes an interrupt it pulses `irq_ack`. On that pulse, each cache whose mode is enabled and whose freeze enable is set drops to the frozen mode. A cache in any other mode keeps it.

Top module: `cache_mode_regs`

## Requirements
- R1: A synchronous active-high reset clears the control word, so a full-word read at byte offset 0x0 returns 0x00000000.
- R2: A full-word write at offset 0x0 stores the write data except bits 14, 15, 16, 21 and 22, which are stored as zero. The field positions are: bits [1:0] instruction mode, bits [3:2] data mode, bit 4 instruction freeze enable, bit 5 data freeze enable, bit 23 snoop enable.
- R3: A full-word read at offset 0x8 returns 0x10220000 and at offset 0xC returns 0x18220000. Writes to these offsets leave every register unchanged.
- R4: Only `acc_size` = 2'b10 is a full 32-bit access. With any other size, a read returns zero and a write changes nothing.
- R5: Every offset other than 0x0, 0x8 and 0xC reads zero, and writes to it change nothing.
- R6: When `irq_ack` is high, bit 4 is set and the instruction mode is 2'b11 (enabled), the instruction mode becomes 2'b01 (frozen) on that clock edge.
- R7: When `irq_ack` is high, bit 5 is set and the data mode is 2'b11, the data mode becomes 2'b01. The two caches are handled independently of each other.
- R8: On `irq_ack`, a mode other than 2'b11 (00 disabled, 01 frozen, or 10) keeps its value, and a mode whose freeze enable is clear keeps its value. All bits other than the two mode fields are unchanged.
- R9: When a control write and `irq_ack` fall in the same cycle, the written value is stored first and the freeze rule is then applied to it, using the newly written freeze enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 2 | Access size; 2'b10 is a full 32-bit word |
| wr_en | input | 1 | Write strobe for the current access |
| wdata | input | 32 | Write data |
| irq_ack | input | 1 | Interrupt-taken pulse from the core |
| rdata | output | 32 | Read data for the addressed register (combinational) |

## Verification
The freeze rule is swept over all 64 combinations of the two mode fields and the two freeze enables. The sweep runs once with the acknowledge alone and once with the acknowledge in the same cycle as the write. This separates a correct freeze from one that uses the wrong enable, crosses the two caches, or acts on the old value instead of the newly written one. The write data in every pattern also sets the cleared command bits, so the write mask is checked against the full field layout. Every byte offset is read and then written with all ones, and the non-word access sizes are tried on the control word. Together these show that only the three decoded offsets answer and only the control offset stores.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int WORD_W = 32;

    // access size codes
    localparam logic [1:0] SZ_WORD = 2'b10;

    // register offsets (byte addresses)
    localparam int OFS_CTL  = 'h0;
    localparam int OFS_ICFG = 'h8;
    localparam int OFS_DCFG = 'hC;

    // fixed configuration words
    localparam logic [WORD_W-1:0] ICFG_WORD = 32'h1022_0000;
    localparam logic [WORD_W-1:0] DCFG_WORD = 32'h1822_0000;

    // control word layout
    localparam int N_CACHE   = 2;     // 0 = instruction, 1 = data
    localparam int MODE_W    = 2;
    localparam int FRZ_BASE  = 4;     // freeze enable for cache g at FRZ_BASE+g
    localparam int SNOOP_BIT = 23;

    // positions that a write never stores
    localparam logic [WORD_W-1:0] WR_DROP_MASK =
        (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) |
        (32'h1 << 21) | (32'h1 << 22);

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'b00,
        MODE_FROZEN = 2'b01,
        MODE_ON     = 2'b11
    } cache_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
    } ccr_state_t;

endpackage

// File: rtl/ccr_freeze.sv
module ccr_freeze
    import ccr_pkg::*;
(
    input  logic [MODE_W-1:0] mode_in,
    input  logic              frz_en,
    input  logic              ack,
    output logic [MODE_W-1:0] mode_out
);

    always_comb begin
        mode_out = mode_in;
        if (ack && frz_en && (mode_in == MODE_W'(MODE_ON))) begin
            mode_out = MODE_W'(MODE_FROZEN);
        end
    end

endmodule

// File: rtl/ccr_read_port.sv
module ccr_read_port
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              full,
    input  logic [WORD_W-1:0] ctl,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(OFS_ICFG);
    localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(OFS_DCFG);

    always_comb begin
        rdata = '0;
        if (full) begin
            unique case (addr)
                A_CTL:   rdata = ctl;
                A_ICFG:  rdata = ICFG_WORD;
                A_DCFG:  rdata = DCFG_WORD;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cache_mode_regs.sv
module cache_mode_regs
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_size,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              irq_ack,
    output logic [31:0]       rdata
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);

    ccr_state_t state_d, state_q;

    logic              full;
    logic              wr_ctl;
    logic [WORD_W-1:0] staged;
    logic [MODE_W-1:0] mode_new [N_CACHE];

    assign full   = (acc_size == SZ_WORD);
    assign wr_ctl = wr_en && full && (addr == A_CTL);
    assign staged = wr_ctl ? (wdata & ~WR_DROP_MASK) : state_q.ctl;

    for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
        ccr_freeze u_frz (
            .mode_in  (staged[g*MODE_W +: MODE_W]),
            .frz_en   (staged[FRZ_BASE + g]),
            .ack      (irq_ack),
            .mode_out (mode_new[g])
        );
    end

    always_comb begin
        state_d.ctl = staged;
        for (int g = 0; g < N_CACHE; g++) begin
            state_d.ctl[g*MODE_W +: MODE_W] = mode_new[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    ccr_read_port #(.ADDR_W(ADDR_W)) u_rd (
        .addr  (addr),
        .full  (full),
        .ctl   (state_q.ctl),
        .rdata (rdata)
    );

    // assertions
    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> state_q.ctl == '0);

    assert_read_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (full && addr == A_CTL) |-> (rdata & WR_DROP_MASK) == '0);

    assert_icfg_R3: assert property (@(posedge clk) disable iff (rst)
        (full && addr == ADDR_W'(OFS_ICFG)) |-> rdata == ICFG_WORD);

    assert_dcfg_R3: assert property (@(posedge clk) disable iff (rst)
        (full && addr == ADDR_W'(OFS_DCFG)) |-> rdata == DCFG_WORD);

    assert_narrow_read_R4: assert property (@(posedge clk) disable iff (rst)
        !full |-> rdata == '0);

    assert_narrow_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !irq_ack) |=> $stable(state_q.ctl));

    assert_other_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != A_CTL && !irq_ack) |=> $stable(state_q.ctl));

    assert_ifreeze_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !wr_ctl && state_q.ctl[FRZ_BASE] && state_q.ctl[1:0] == 2'b11)
        |=> state_q.ctl[1:0] == 2'b01);

    assert_dfreeze_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !wr_ctl && state_q.ctl[FRZ_BASE+1] && state_q.ctl[3:2] == 2'b11)
        |=> state_q.ctl[3:2] == 2'b01);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !wr_ctl && state_q.ctl[1:0] != 2'b11 && state_q.ctl[3:2] != 2'b11)
        |=> $stable(state_q.ctl));

    assert_wr_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && wr_ctl && wdata[FRZ_BASE] && wdata[1:0] == 2'b11)
        |=> state_q.ctl[1:0] == 2'b01);

endmodule

// File: tb/cache_mode_regs_tb.sv
module cache_mode_regs_tb;

    localparam int ADDR_W = 8;
    localparam logic [31:0] DROP = 32'h0061_C000;
    localparam logic [31:0] ICFG = 32'h1022_0000;
    localparam logic [31:0] DCFG = 32'h1822_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        acc_size = 2'b10;
    logic              wr_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic              irq_ack = 1'b0;
    logic [31:0]       rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_ctl = '0;

    always #10 clk = ~clk;

    cache_mode_regs #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .acc_size(acc_size),
        .wr_en(wr_en), .wdata(wdata), .irq_ack(irq_ack), .rdata(rdata)
    );

    function automatic logic [31:0] model(input logic [31:0] old, input logic [31:0] d,
                                          input logic wr, input logic ack);
        logic [31:0] v;
        v = wr ? (d & ~DROP) : old;
        if (ack) begin
            if (v[4] && v[1:0] == 2'b11) v[1:0] = 2'b01;
            if (v[5] && v[3:2] == 2'b11) v[3:2] = 2'b01;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                          input logic we, input logic [31:0] d, input logic ack);
        @(negedge clk);
        addr = a; acc_size = sz; wr_en = we; wdata = d; irq_ack = ack;
        @(negedge clk);
        wr_en = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a,
                            input logic [1:0] sz, input logic [31:0] exp);
        addr = a; acc_size = sz;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        read_chk("R1", 8'h00, 2'b10, 32'h0);

        // R2 R6 R7 R8: all mode/enable patterns, acknowledge alone
        for (int p = 0; p < 64; p++) begin
            logic [31:0] d;
            d = 32'h0061_C000 | 32'(p) | (32'(p & 1) << 23);
            access(8'h00, 2'b10, 1'b1, d, 1'b0);
            m_ctl = model(m_ctl, d, 1'b1, 1'b0);
            read_chk("R2", 8'h00, 2'b10, m_ctl);
            access(8'h00, 2'b10, 1'b0, 32'h0, 1'b1);
            m_ctl = model(m_ctl, 32'h0, 1'b0, 1'b1);
            read_chk("R6 R7 R8", 8'h00, 2'b10, m_ctl);
        end

        // R9: write and acknowledge in the same cycle
        for (int p = 0; p < 64; p++) begin
            logic [31:0] d;
            d = 32'hFFFF_FFC0 | 32'(p);
            access(8'h00, 2'b10, 1'b1, d, 1'b1);
            m_ctl = model(m_ctl, d, 1'b1, 1'b1);
            read_chk("R9", 8'h00, 2'b10, m_ctl);
        end

        // R4: narrow accesses
        access(8'h00, 2'b10, 1'b1, 32'h0080_003F, 1'b0);
        m_ctl = model(m_ctl, 32'h0080_003F, 1'b1, 1'b0);
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            access(8'h00, 2'(s), 1'b1, 32'h0000_0000, 1'b0);
            read_chk("R4", 8'h00, 2'(s), 32'h0);
            read_chk("R4", 8'h0C, 2'(s), 32'h0);
            read_chk("R4", 8'h00, 2'b10, m_ctl);
        end

        // R3 R5: every offset read, then written with all ones
        for (int a = 0; a < 256; a++) begin
            logic [31:0] e;
            if (a == 0)       e = m_ctl;
            else if (a == 8)  e = ICFG;
            else if (a == 12) e = DCFG;
            else              e = 32'h0;
            read_chk((a == 8 || a == 12) ? "R3" : "R5", 8'(a), 2'b10, e);
            if (a != 0) begin
                access(8'(a), 2'b10, 1'b1, 32'hFFFF_FFFF, 1'b0);
                read_chk((a == 8 || a == 12) ? "R3" : "R5", 8'h00, 2'b10, m_ctl);
            end
        end
        read_chk("R3", 8'h08, 2'b10, ICFG);
        read_chk("R3", 8'h0C, 2'b10, DCFG);

        // R1: reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ctl = '0;
        read_chk("R1", 8'h00, 2'b10, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule